// File: doc/BRIEF.md
# Two-Dimensional Rectangle Fill and Copy Engine

This engine runs rectangle operations on a byte memory seen as a square grid of `2^CW` rows by `2^CW` columns. The upper half of an address selects the row and the lower half selects the column. A caller loads a destination corner, a size, a fill byte and a source corner, then pulses `start` and picks a command. The fill command stores one constant byte into every cell of the destination rectangle. The copy command moves a source rectangle of the same size onto the destination.

Rows and columns each wrap around the grid edge on their own axis, so a rectangle can run off the bottom or the right side and continue at the top or the left. When the copy areas overlap, the engine picks its traversal direction so that no source byte is overwritten before it has been read. The engine drives a single-port synchronous memory and makes at most one access per clock. It reports `busy` while it works and pulses `done` once when it finishes.

Top module: `grid_fill_blit`

## Requirements
- R1: Every cell of the destination rectangle is written exactly once. A cell at row `r` and column `c` is at address `{r, c}`, with the row in the upper `CW` bits and the column in the lower `CW` bits.
- R2: Fill (`cmdBlit`=0) writes the sampled `fillValue` into every destination cell. It makes one write per cycle and no reads, so `busy` stays high for exactly height×width cycles.
- R3: Row and column indices each wrap modulo `2^CW`, independently of each other.
- R4: Copy (`cmdBlit`=1) alternates a read cycle at the source cell with a write cycle at the matching destination cell. Read and write are never asserted together, and `busy` stays high for 2×height×width cycles.
- R5: If the destination corner, taken as a linear address, is greater than the source corner, a copy starts at the bottom-right cell and steps the column down before the row. Otherwise it starts at the top-left cell and steps the column up before the row. Fill always starts at the top-left cell.
- R6: For overlapping rectangles that do not wrap, the destination ends up holding the original source contents.
- R7: A height or width of zero (`size` upper or lower byte = 0) makes no memory access, never raises `busy`, and raises `done` in the cycle after the cycle in which `start` was sampled.
- R8: A `start` that arrives while `busy` is high is ignored.
- R9: The corner, size, value and command inputs are captured when `start` is accepted. Changes to these inputs while `busy` is high have no effect.
- R10: `done` is high for exactly one cycle, the cycle after the last write. `busy` falls in that same cycle.
- R11: After reset, `busy`, `done`, `memWe` and `memRe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a command when the engine is idle |
| cmdBlit | input | 1 | 1 = copy, 0 = fill |
| dstOrigin | input | 2*CW | Destination top-left corner: row in the upper half, column in the lower half |
| size | input | 2*CW | Rectangle size: height in the upper half, width in the lower half |
| fillValue | input | DW | Byte written by a fill |
| srcOrigin | input | 2*CW | Source top-left corner: row in the upper half, column in the lower half |
| memRdata | input | DW | Read data, valid in the cycle after a read |
| memAddr | output | 2*CW | Memory address |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memWdata | output | DW | Memory write data |
| busy | output | 1 | High while a command runs |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with `CW`=4, which gives a 16 by 16 grid of 256 bytes. A full shadow copy of the memory can then be compared after every command. Rectangles that straddle both the right and bottom edges only need a few cells. With the small grid, overlap in both traversal directions, wrap on each axis and the zero-size cases all fit into short runs. Each run is also checked for its write count, the address of its first write and the position of `done` relative to the last write.

// File: rtl/fillblit_pkg.sv
package fillblit_pkg;
  // Strobes from the sequencer to the address/data path.
  typedef struct packed {
    logic load;    // capture command inputs
    logic step;    // advance to the next cell
    logic rdEn;    // memory read this cycle
    logic wrEn;    // memory write this cycle
    logic selSrc;  // drive source address instead of destination
    logic active;  // a command is in progress
  } fbStrobe_t;
endpackage

// File: rtl/grid_fill_blit_dp.sv
module grid_fill_blit_dp
  import fillblit_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbStrobe_t         strb,
  input  logic              cmdBlit,
  input  logic [2*CW-1:0]   dstOrigin,
  input  logic [2*CW-1:0]   size,
  input  logic [DW-1:0]     fillValue,
  input  logic [2*CW-1:0]   srcOrigin,
  input  logic [DW-1:0]     memRdata,
  output logic [2*CW-1:0]   memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              lastCell,
  output logic              sizeZero
);
  localparam int AW = 2 * CW;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] dstRow, dstCol, srcRow, srcCol, hgt, wid, rowOff, colOff;
  logic [DW-1:0] valQ;
  logic          blitQ, backQ;
  logic          goBack;

  assign sizeZero = (size[AW-1:CW] == '0) || (size[CW-1:0] == '0);
  assign goBack   = cmdBlit && (dstOrigin > srcOrigin);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstRow <= '0; dstCol <= '0; srcRow <= '0; srcCol <= '0;
      hgt    <= '0; wid    <= '0; valQ   <= '0;
      blitQ  <= 1'b0; backQ <= 1'b0;
      rowOff <= '0; colOff <= '0;
    end else if (strb.load) begin
      dstRow <= dstOrigin[AW-1:CW];
      dstCol <= dstOrigin[CW-1:0];
      srcRow <= srcOrigin[AW-1:CW];
      srcCol <= srcOrigin[CW-1:0];
      hgt    <= size[AW-1:CW];
      wid    <= size[CW-1:0];
      valQ   <= fillValue;
      blitQ  <= cmdBlit;
      backQ  <= goBack;
      rowOff <= goBack ? size[AW-1:CW] - ONE : '0;
      colOff <= goBack ? size[CW-1:0] - ONE : '0;
    end else if (strb.step) begin
      if (backQ) begin
        if (colOff == '0) begin
          colOff <= wid - ONE;
          rowOff <= rowOff - ONE;
        end else begin
          colOff <= colOff - ONE;
        end
      end else begin
        if (colOff == wid - ONE) begin
          colOff <= '0;
          rowOff <= rowOff + ONE;
        end else begin
          colOff <= colOff + ONE;
        end
      end
    end
  end

  assign lastCell = backQ ? ((rowOff == '0) && (colOff == '0))
                          : ((rowOff == hgt - ONE) && (colOff == wid - ONE));

  logic [CW-1:0] curRow, curCol;
  always_comb begin
    if (strb.selSrc) begin
      curRow = srcRow + rowOff;
      curCol = srcCol + colOff;
    end else begin
      curRow = dstRow + rowOff;
      curCol = dstCol + colOff;
    end
  end

  assign memAddr  = {curRow, curCol};
  assign memWdata = blitQ ? memRdata : valQ;

  // R1
  offset_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |-> (rowOff < hgt) && (colOff < wid));

  // R2
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !blitQ) |-> !strb.rdEn);

  // R9
  origin_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.load) |=> $stable(dstRow) && $stable(srcCol) && $stable(wid));
endmodule

// File: rtl/grid_fill_blit_ctrl.sv
module grid_fill_blit_ctrl
  import fillblit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmdBlit,
  input  logic      sizeZero,
  input  logic      lastCell,
  output fbStrobe_t strb,
  output logic      busy,
  output logic      done
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} fbState_e;

  fbState_e state;
  logic     doneQ;

  always_comb begin
    strb        = '0;
    strb.active = (state != S_IDLE);
    case (state)
      S_IDLE: strb.load = start;
      S_FILL: begin strb.wrEn = 1'b1; strb.step = !lastCell; end
      S_RD:   begin strb.rdEn = 1'b1; strb.selSrc = 1'b1; end
      S_WR:   begin strb.wrEn = 1'b1; strb.step = !lastCell; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (sizeZero) doneQ <= 1'b1;
          else          state <= cmdBlit ? S_RD : S_FILL;
        end
        S_FILL: if (lastCell) begin state <= S_IDLE; doneQ <= 1'b1; end
        S_RD:   state <= S_WR;
        S_WR:   if (lastCell) begin state <= S_IDLE; doneQ <= 1'b1; end
                else state <= S_RD;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> strb.wrEn);

  // R4
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.wrEn));

  // R8
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !strb.wrEn) |=> busy);
endmodule

// File: rtl/grid_fill_blit.sv
module grid_fill_blit
  import fillblit_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            cmdBlit,
  input  logic [2*CW-1:0] dstOrigin,
  input  logic [2*CW-1:0] size,
  input  logic [DW-1:0]   fillValue,
  input  logic [2*CW-1:0] srcOrigin,
  input  logic [DW-1:0]   memRdata,
  output logic [2*CW-1:0] memAddr,
  output logic            memWe,
  output logic            memRe,
  output logic [DW-1:0]   memWdata,
  output logic            busy,
  output logic            done
);
  fbStrobe_t strb;
  logic      lastCell, sizeZero;

  grid_fill_blit_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdBlit(cmdBlit),
    .sizeZero(sizeZero), .lastCell(lastCell),
    .strb(strb), .busy(busy), .done(done)
  );

  grid_fill_blit_dp #(.CW(CW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdBlit(cmdBlit),
    .dstOrigin(dstOrigin), .size(size), .fillValue(fillValue),
    .srcOrigin(srcOrigin), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .lastCell(lastCell), .sizeZero(sizeZero)
  );

  assign memWe = strb.wrEn;
  assign memRe = strb.rdEn;

  // R11
  no_idle_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe && !memRe);
endmodule

// File: tb/grid_fill_blit_tb_top.sv
module grid_fill_blit_tb_top;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int NV = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, cmdBlit = 1'b0;
  logic [7:0] dstOrigin = '0, size = '0, srcOrigin = '0;
  logic [7:0] fillValue = '0, memRdata, memAddr, memWdata;
  logic memWe, memRe, busy, done;

  always #2 clk = ~clk;

  grid_fill_blit #(.CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdBlit(cmdBlit),
    .dstOrigin(dstOrigin), .size(size), .fillValue(fillValue),
    .srcOrigin(srcOrigin), .memRdata(memRdata), .memAddr(memAddr),
    .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .busy(busy), .done(done)
  );

  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic [7:0] snap [256];
  logic [7:0] rdQ;
  assign memRdata = rdQ;

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) rdQ <= mem[memAddr];
  end

  int checks = 0, errors = 0;
  int cyc = 0, busyCyc = 0, wrCnt = 0, rdCnt = 0, bothCnt = 0;
  int doneCnt = 0, doneCyc = 0, lastWrCyc = 0;
  logic doneBusy = 1'b0;
  logic [7:0] firstAddr = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (busy) busyCyc <= busyCyc + 1;
    if (memWe) begin
      if (wrCnt == 0) firstAddr <= memAddr;
      wrCnt <= wrCnt + 1;
      lastWrCyc <= cyc;
    end
    if (memRe) rdCnt <= rdCnt + 1;
    if (memWe && memRe) bothCnt <= bothCnt + 1;
    if (done) begin doneCnt <= doneCnt + 1; doneCyc <= cyc; doneBusy <= busy; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearCounters();
    @(negedge clk); #1;
    busyCyc = 0; wrCnt = 0; rdCnt = 0; bothCnt = 0; doneCnt = 0;
  endtask

  task automatic applyModel(input bit b, input logic [7:0] d, input logic [7:0] s,
                            input logic [7:0] v, input logic [7:0] sr);
    for (int k = 0; k < 256; k++) snap[k] = model[k];
    for (int i = 0; i < int'(s[7:4]); i++)
      for (int j = 0; j < int'(s[3:0]); j++) begin
        logic [3:0] dr, dc, rr, rc;
        dr = d[7:4] + 4'(i);  dc = d[3:0] + 4'(j);
        rr = sr[7:4] + 4'(i); rc = sr[3:0] + 4'(j);
        model[{dr, dc}] = b ? snap[{rr, rc}] : v;
      end
  endtask

  task automatic compareMem(input string req);
    int bad = 0;
    for (int k = 0; k < 256; k++) if (mem[k] !== model[k]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic runOp(input bit b, input logic [7:0] d, input logic [7:0] s,
                       input logic [7:0] v, input logic [7:0] sr);
    int guard = 0;
    clearCounters();
    cmdBlit = b; dstOrigin = d; size = s; fillValue = v; srcOrigin = sr;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    while (doneCnt == 0 && guard < 2000) begin
      @(negedge clk); #1;
      guard++;
    end
    @(negedge clk); #1;
    @(negedge clk); #1;
    applyModel(b, d, s, v, sr);
  endtask

  // blit, dst, size, val, src, expected first write address
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h23, 8'h34, 8'hA5, 8'h00, 8'h23},
    {1'b0, 8'hEE, 8'h33, 8'h5C, 8'h00, 8'hEE},
    {1'b1, 8'h10, 8'h23, 8'h00, 8'h80, 8'h10},
    {1'b1, 8'h90, 8'h22, 8'h00, 8'h11, 8'hA1},
    {1'b1, 8'h33, 8'h44, 8'h00, 8'h22, 8'h66},
    {1'b1, 8'h44, 8'h33, 8'h00, 8'h55, 8'h44},
    {1'b1, 8'hFF, 8'h22, 8'h00, 8'h44, 8'h00},
    {1'b1, 8'h71, 8'h16, 8'h00, 8'h72, 8'h71}
  };

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem[k] = 8'((k * 37 + 11) & 8'hFF);
      model[k] = 8'((k * 37 + 11) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0 && done === 1'b0 && memWe === 1'b0 && memRe === 1'b0,
        "R11 reset outputs", {busy, done, memWe, memRe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      logic b; logic [7:0] d, s, v, sr, ef; int cells;
      {b, d, s, v, sr, ef} = VEC[n];
      cells = int'(s[7:4]) * int'(s[3:0]);
      runOp(b, d, s, v, sr);
      compareMem(b ? "R6/R4/R3 copy contents" : "R2/R3 fill contents");
      chk(wrCnt == cells, "R1 write count", wrCnt, cells);
      chk(firstAddr == ef, "R5 first write address", firstAddr, ef);
      chk(rdCnt == (b ? cells : 0) && bothCnt == 0, "R4/R2 read count", rdCnt, b ? cells : 0);
      chk(busyCyc == (b ? 2 * cells : cells), "R2/R4 busy cycles", busyCyc, b ? 2 * cells : cells);
      chk(doneCnt == 1 && doneCyc == lastWrCyc + 1 && doneBusy == 1'b0,
          "R10 done timing", doneCyc - lastWrCyc, 1);
    end

    // R7 zero width, then zero height
    for (int z = 0; z < 2; z++) begin
      clearCounters();
      cmdBlit = 1'b0; dstOrigin = 8'h00; size = (z == 0) ? 8'h30 : 8'h03; fillValue = 8'hEE;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      chk(done === 1'b1 && busy === 1'b0, "R7 done one cycle after start", {done, busy}, 2);
      @(negedge clk); #1;
      chk(done === 1'b0, "R7 done pulse ends", done, 0);
      @(negedge clk); #1;
      chk(wrCnt == 0 && busyCyc == 0, "R7 no writes", wrCnt, 0);
      compareMem("R7 memory untouched");
    end

    // R8/R9 start and input changes while busy
    begin
      int guard = 0;
      clearCounters();
      cmdBlit = 1'b0; dstOrigin = 8'h00; size = 8'h44; fillValue = 8'h11; srcOrigin = 8'h00;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      cmdBlit = 1'b1; dstOrigin = 8'h88; size = 8'h22; fillValue = 8'h99; srcOrigin = 8'hCC;
      start = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      start = 1'b0;
      while (doneCnt == 0 && guard < 2000) begin
        @(negedge clk); #1;
        guard++;
      end
      @(negedge clk); #1;
      @(negedge clk); #1;
      applyModel(1'b0, 8'h00, 8'h44, 8'h11, 8'h00);
      compareMem("R8/R9 only first command applied");
      chk(wrCnt == 16 && rdCnt == 0, "R8 write count", wrCnt, 16);
      chk(busyCyc == 16 && doneCnt == 1, "R9 busy cycles", busyCyc, 16);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule